// File: doc/BRIEF.md
# Capture and Auto-Reload Timer

A 16-bit up-counting timer/counter with an eight-bit control register, a 16-bit capture/reload register pair and a falling-edge trigger input. Each count step comes either from an internal tick strobe or from a falling edge on an external count pin. Three ways of working are selected through the control register. In reload mode the count is reloaded from the pair when it rolls over. In capture mode a trigger edge copies the running count into the pair. In baud-clock mode every rollover gives a one-cycle pulse on the receive-clock and/or transmit-clock output.

Software reaches the control register, both count bytes and both reload bytes through a byte-wide register port. The port writes on the clock edge and reads combinationally. An overflow flag and an external-event flag live in the control register. Their OR drives the interrupt request output.

Top module: `capture_reload_timer`

## Requirements
- R1: After reset the control register, the count and the reload pair all read 0, and irq, rx_clk_pulse and tx_clk_pulse are 0.
- R2: While the run bit (control bit 2) is 1 and the count-source bit (control bit 1) is 0, each clock with tick high adds one to the count. While the run bit is 0 the count holds.
- R3: When the count steps from 0xFFFF, the overflow flag (control bit 7) is set and irq goes to 1. With the mode bit (control bit 0) at 0 the count is loaded from the reload pair. The flag stays set until software writes 0 to it.
- R4: With the receive-clock enable (bit 5) or the transmit-clock enable (bit 4) set, a rollover does not set the overflow flag. It always reloads the count from the pair, whatever the mode bit says. One clock later it gives a one-cycle pulse on rx_clk_pulse if bit 5 is set and on tx_clk_pulse if bit 4 is set.
- R5: With the trigger-enable bit (bit 3) and the mode bit set, a falling edge on trig_pin copies the count into the reload pair and sets the external flag (bit 6). The count itself carries on unchanged. The action takes effect on the third rising clock edge after the pin falls.
- R6: With the trigger-enable bit set and the mode bit at 0, a falling edge on trig_pin loads the count from the reload pair and sets the external flag.
- R7: Trigger edges have no effect on the count, the pair or the external flag when the trigger-enable bit is 0, or when either clock enable (bit 5 or bit 4) is set.
- R8: With the count-source bit at 1, the count advances once for each falling edge on cnt_pin and ignores tick.
- R9: When the hardware sets a flag in the same cycle that software writes 0 to it, the flag ends up set.
- R10: A write to either count byte replaces that byte. In that cycle it suppresses the increment, the reload and the overflow.
- R11: With the mode bit at 1, a rollover wraps the count to 0 and still sets the overflow flag.
- R12: The register port uses these addresses: 0 control, 1 count low, 2 count high, 3 reload low, 4 reload high. Each byte written reads back. Addresses 5 to 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Internal count strobe |
| cnt_pin | input | 1 | External count pin, falling-edge active |
| trig_pin | input | 1 | External capture/reload trigger, falling-edge active |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request, OR of both flags |
| rx_clk_pulse | output | 1 | Receive baud pulse per rollover |
| tx_clk_pulse | output | 1 | Transmit baud pulse per rollover |

## Verification
The hardest case to reach is a hardware flag set and a software flag clear landing in the same clock. The second hardest is a counter write colliding with an increment. Both need exact cycle alignment between a register write and an event. The bench reaches them by preloading the count with 0xFFFF through the port and then driving tick together with the write strobe in a single cycle. Trigger tests hold tick low, so the count is known when the synchronized edge takes effect three edges later.

// File: rtl/crt_pkg.sv
package crt_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_CNT_LO = 3'd1,
    A_CNT_HI = 3'd2,
    A_RLD_LO = 3'd3,
    A_RLD_HI = 3'd4
  } crt_addr_e;

  typedef struct packed {
    logic ovf_flag;
    logic ext_flag;
    logic rx_en;
    logic tx_en;
    logic trig_en;
    logic run;
    logic src_ext;
    logic cap_mode;
  } crt_ctrl_t;
endpackage

// File: rtl/crt_edge_sync.sv
module crt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/crt_count_core.sv
module crt_count_core #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inc,
  input  logic                reload_on_ovf,
  input  logic                ext_reload,
  input  logic                ext_capture,
  input  logic                wr_cnt_lo,
  input  logic                wr_cnt_hi,
  input  logic                wr_rld_lo,
  input  logic                wr_rld_hi,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [2*BYTE_W-1:0] count,
  output logic [2*BYTE_W-1:0] rld,
  output logic                ovf
);
  localparam int CW = 2 * BYTE_W;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic sw_cnt;
  assign sw_cnt = wr_cnt_lo | wr_cnt_hi;
  assign ovf    = inc & (&count) & ~sw_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (sw_cnt) begin
      if (wr_cnt_lo) count[BYTE_W-1:0]  <= wdata;
      if (wr_cnt_hi) count[CW-1:BYTE_W] <= wdata;
    end else if (ext_reload || (ovf && reload_on_ovf)) begin
      count <= rld;
    end else if (inc) begin
      count <= count + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rld <= '0;
    end else if (ext_capture) begin
      rld <= count;
    end else begin
      if (wr_rld_lo) rld[BYTE_W-1:0]  <= wdata;
      if (wr_rld_hi) rld[CW-1:BYTE_W] <= wdata;
    end
  end
endmodule

// File: rtl/capture_reload_timer.sv
module capture_reload_timer
  import crt_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq,
  output logic              rx_clk_pulse,
  output logic              tx_clk_pulse
);
  localparam int CW   = 2 * BYTE_W;
  localparam int NPIN = 2;

  crt_ctrl_t        ctrl;
  logic [NPIN-1:0]  pins, falls;
  logic             cnt_fall, trig_fall;
  logic             baud, inc, ext_evt, ovf, wr_ctl;
  logic [CW-1:0]    count, rld;

  assign pins = {trig_pin, cnt_pin};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    crt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .pin (pins[g]),
      .fall(falls[g])
    );
  end

  assign cnt_fall  = falls[0];
  assign trig_fall = falls[1];

  assign baud    = ctrl.rx_en | ctrl.tx_en;
  assign inc     = ctrl.run & (ctrl.src_ext ? cnt_fall : tick);
  assign ext_evt = ctrl.trig_en & ~baud & trig_fall;
  assign wr_ctl  = reg_wr && (reg_addr == A_CTRL);

  crt_count_core #(.BYTE_W(BYTE_W)) u_core (
    .clk          (clk),
    .rst          (rst),
    .inc          (inc),
    .reload_on_ovf(baud | ~ctrl.cap_mode),
    .ext_reload   (ext_evt & ~ctrl.cap_mode),
    .ext_capture  (ext_evt & ctrl.cap_mode),
    .wr_cnt_lo    (reg_wr && (reg_addr == A_CNT_LO)),
    .wr_cnt_hi    (reg_wr && (reg_addr == A_CNT_HI)),
    .wr_rld_lo    (reg_wr && (reg_addr == A_RLD_LO)),
    .wr_rld_hi    (reg_wr && (reg_addr == A_RLD_HI)),
    .wdata        (reg_wdata),
    .count        (count),
    .rld          (rld),
    .ovf          (ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl         <= '0;
      rx_clk_pulse <= 1'b0;
      tx_clk_pulse <= 1'b0;
    end else begin
      if (wr_ctl) ctrl <= crt_ctrl_t'(reg_wdata);
      // hardware set beats a same-cycle software clear (R9)
      ctrl.ovf_flag <= (ovf & ~baud) | (wr_ctl ? reg_wdata[7] : ctrl.ovf_flag);
      ctrl.ext_flag <= ext_evt | (wr_ctl ? reg_wdata[6] : ctrl.ext_flag);
      rx_clk_pulse  <= ovf & ctrl.rx_en;
      tx_clk_pulse  <= ovf & ctrl.tx_en;
    end
  end

  assign irq = ctrl.ovf_flag | ctrl.ext_flag;

  always_comb begin
    unique case (reg_addr)
      A_CTRL:   reg_rdata = ctrl;
      A_CNT_LO: reg_rdata = count[BYTE_W-1:0];
      A_CNT_HI: reg_rdata = count[CW-1:BYTE_W];
      A_RLD_LO: reg_rdata = rld[BYTE_W-1:0];
      A_RLD_HI: reg_rdata = rld[CW-1:BYTE_W];
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/crt_checker.sv
module crt_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ovf,
  input logic          baud,
  input logic          wr_ctl,
  input logic          ext_evt,
  input logic          trig_fall,
  input logic          trig_en,
  input logic          cap_mode,
  input logic          run,
  input logic          ovf_flag,
  input logic          ext_flag,
  input logic          rx_en,
  input logic          tx_en,
  input logic          rx_clk_pulse,
  input logic          tx_clk_pulse,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [CW-1:0] count,
  input logic [CW-1:0] rld
);
  assert_flag_on_ovf_R3: assert property (@(posedge clk) disable iff (rst)
    (ovf && !baud) |=> ovf_flag);

  assert_no_flag_in_baud_R4: assert property (@(posedge clk) disable iff (rst)
    (ovf && baud && !wr_ctl) |=> $stable(ovf_flag));

  assert_rx_pulse_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    rx_clk_pulse |-> $past(rx_en));

  assert_tx_pulse_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    tx_clk_pulse |-> $past(tx_en));

  assert_ext_flag_R5: assert property (@(posedge clk) disable iff (rst)
    ext_evt |=> ext_flag);

  assert_capture_copy_R5: assert property (@(posedge clk) disable iff (rst)
    (ext_evt && cap_mode) |=> (rld == $past(count)));

  assert_trig_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (trig_fall && (!trig_en || baud) && !wr_ctl && !ovf) |=> $stable(ext_flag));

  assert_stopped_R2: assert property (@(posedge clk) disable iff (rst)
    (!run && !ext_evt && !(reg_wr && (reg_addr == 3'd1 || reg_addr == 3'd2)))
      |=> $stable(count));
endmodule

bind capture_reload_timer crt_checker #(.CW(2 * BYTE_W)) u_crt_checker (
  .clk         (clk),
  .rst         (rst),
  .ovf         (ovf),
  .baud        (baud),
  .wr_ctl      (wr_ctl),
  .ext_evt     (ext_evt),
  .trig_fall   (trig_fall),
  .trig_en     (ctrl.trig_en),
  .cap_mode    (ctrl.cap_mode),
  .run         (ctrl.run),
  .ovf_flag    (ctrl.ovf_flag),
  .ext_flag    (ctrl.ext_flag),
  .rx_en       (ctrl.rx_en),
  .tx_en       (ctrl.tx_en),
  .rx_clk_pulse(rx_clk_pulse),
  .tx_clk_pulse(tx_clk_pulse),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .count       (count),
  .rld         (rld)
);

// File: tb/capture_reload_timer_bench.sv
module capture_reload_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, cnt_pin = 1'b1, trig_pin = 1'b1;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, rx_clk_pulse, tx_clk_pulse;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_reload_timer u_capture_reload_timer (
    .clk(clk), .rst(rst), .tick(tick), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq),
    .rx_clk_pulse(rx_clk_pulse), .tx_clk_pulse(tx_clk_pulse)
  );

  // {addr, write data, expected read-back}
  localparam logic [18:0] VEC [0:6] = '{
    {3'd3, 8'hA5, 8'hA5}, {3'd4, 8'h5A, 8'h5A}, {3'd1, 8'h3C, 8'h3C},
    {3'd2, 8'hC3, 8'hC3}, {3'd0, 8'h2A, 8'h2A}, {3'd0, 8'h00, 8'h00},
    {3'd5, 8'hFF, 8'h00}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l); rd(lo + 3'd1, h); v = {h, l};
  endtask

  task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
    wr(lo, v[7:0]); wr(lo + 3'd1, v[15:8]);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic trig_edge();
    @(negedge clk); trig_pin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic trig_restore();
    trig_pin = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, b); chk("R1 ctrl", 16'(b), 16'h0);
    rd16(3'd1, v); chk("R1 count", v, 16'h0);
    rd16(3'd3, v); chk("R1 reload", v, 16'h0);
    chk("R1 outputs", {13'd0, irq, rx_clk_pulse, tx_clk_pulse}, 16'h0);

    // R12 register table walk
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], b);
      chk("R12 regport", 16'(b), 16'(VEC[i][7:0]));
    end

    // R2 counting and stop
    wr16(3'd1, 16'h0000); wr(3'd0, 8'h04);
    ticks(5);
    rd16(3'd1, v); chk("R2 count", v, 16'h0005);
    wr(3'd0, 8'h00); ticks(3);
    rd16(3'd1, v); chk("R2 stopped", v, 16'h0005);

    // R3 overflow with reload
    wr16(3'd3, 16'h1234); wr16(3'd1, 16'hFFFE); wr(3'd0, 8'h04);
    ticks(2);
    rd16(3'd1, v); chk("R3 reload", v, 16'h1234);
    rd(3'd0, b); chk("R3 flag", 16'(b), 16'h84);
    chk("R3 irq", 16'(irq), 16'h1);
    ticks(1);
    chk("R3 flag sticky", 16'(irq), 16'h1);
    wr(3'd0, 8'h04);
    chk("R3 clear", 16'(irq), 16'h0);

    // R11 capture-mode wrap
    wr16(3'd1, 16'hFFFF); wr(3'd0, 8'h05);
    ticks(1);
    rd16(3'd1, v); chk("R11 wrap", v, 16'h0000);
    rd(3'd0, b); chk("R11 flag", 16'(b), 16'h85);
    wr(3'd0, 8'h00);

    // R4 baud mode, both enables, capture bit set but forced reload
    wr16(3'd3, 16'hFFF0); wr16(3'd1, 16'hFFFF); wr(3'd0, 8'h35);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R4 pulses", {14'd0, rx_clk_pulse, tx_clk_pulse}, 16'h3);
    @(negedge clk);
    chk("R4 pulse width", {14'd0, rx_clk_pulse, tx_clk_pulse}, 16'h0);
    rd16(3'd1, v); chk("R4 forced reload", v, 16'hFFF0);
    rd(3'd0, b); chk("R4 no flag", 16'(b), 16'h35);
    wr16(3'd1, 16'hFFFF); wr(3'd0, 8'h24);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R4 rx only", {14'd0, rx_clk_pulse, tx_clk_pulse}, 16'h2);
    wr(3'd0, 8'h00);

    // R5 capture on trigger edge
    wr16(3'd1, 16'h0042); wr16(3'd3, 16'h0000); wr(3'd0, 8'h0D);
    trig_edge();
    rd16(3'd3, v); chk("R5 capture", v, 16'h0042);
    rd16(3'd1, v); chk("R5 count kept", v, 16'h0042);
    rd(3'd0, b); chk("R5 ext flag", 16'(b), 16'h4D);
    trig_restore();
    wr(3'd0, 8'h00);

    // R6 reload on trigger edge
    wr16(3'd3, 16'h0100); wr16(3'd1, 16'h0555); wr(3'd0, 8'h0C);
    trig_edge();
    rd16(3'd1, v); chk("R6 edge reload", v, 16'h0100);
    rd(3'd0, b); chk("R6 ext flag", 16'(b), 16'h4C);
    trig_restore();

    // R7 trigger ignored: disabled, then baud mode
    wr(3'd0, 8'h04); wr16(3'd1, 16'h0777);
    trig_edge();
    rd16(3'd1, v); chk("R7 disabled count", v, 16'h0777);
    rd(3'd0, b); chk("R7 disabled flag", 16'(b), 16'h04);
    trig_restore();
    wr(3'd0, 8'h1C);
    trig_edge();
    rd16(3'd1, v); chk("R7 baud count", v, 16'h0777);
    rd(3'd0, b); chk("R7 baud flag", 16'(b), 16'h1C);
    trig_restore();

    // R8 external count source, tick ignored
    wr(3'd0, 8'h00); wr16(3'd1, 16'h0000); wr(3'd0, 8'h06);
    tick = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); cnt_pin = 1'b0;
      repeat (3) @(negedge clk);
      cnt_pin = 1'b1;
      repeat (3) @(negedge clk);
    end
    tick = 1'b0;
    rd16(3'd1, v); chk("R8 edge count", v, 16'h0003);
    wr(3'd0, 8'h00);

    // R9 hardware set wins over software clear
    wr16(3'd3, 16'h0000); wr16(3'd1, 16'hFFFF); wr(3'd0, 8'h04);
    @(negedge clk); tick = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h04;
    @(negedge clk); tick = 1'b0; reg_wr = 1'b0;
    rd(3'd0, b); chk("R9 set wins", 16'(b[7]), 16'h1);
    wr(3'd0, 8'h04);

    // R10 software count write beats increment
    wr16(3'd1, 16'h0010);
    @(negedge clk); tick = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h80;
    @(negedge clk); tick = 1'b0; reg_wr = 1'b0;
    rd16(3'd1, v); chk("R10 write priority", v, 16'h0080);

    finish_run();
  end
endmodule